// File: doc/BRIEF.md
# Replicated Register Bank with Steering

This block holds many copies of one configuration register that all answer at a single bus address. Each copy belongs to one hardware unit, and a unit can be missing or asleep: an availability mask input marks which copies are present. A steering selector register picks one copy by group and instance number, and its multicast bit decides whether a write reaches every present copy or only the steered one. Reads always return one copy, the steered one, and a copy that is absent reads as zero.

Several agents may share the selector, so a hardware semaphore sits beside it. Reading the semaphore takes it when it is free and reports whether the reader won; writing a 1 frees it. Software takes the semaphore, programs the selector, does its access, and releases the semaphore.

The bus is a plain strobe interface: `wr_en` and `rd_en` with an address and write data. Read data is registered and valid in the cycle after the read strobe.

Top module: `steer_bank`

## Requirements
- R1: After reset the selector reads 0x8000_0000 (multicast set, group 0, instance 0), every copy reads 0, and the semaphore is free.
- R2: The selector at address SEL_ADDR (default 0x10) stores the instance number in bits 7:0, the group number in bits 15:8 and the multicast flag in bit 31; other bits read as 0.
- R3: A write to REG_ADDR (default 0x20) with the multicast flag set loads the write data into every copy whose availability bit is 1 and leaves the other copies unchanged.
- R4: A write to REG_ADDR with the multicast flag clear loads only the copy at index group × PER_GROUP + instance (PER_GROUP default 4).
- R5: A read of REG_ADDR returns the steered copy whatever the multicast flag holds.
- R6: A steered copy is unreachable when its availability bit is 0, or when group ≥ GROUPS or instance ≥ PER_GROUP; reads of an unreachable copy return 0 and unicast writes to it change no copy.
- R7: A read of SEM_ADDR (default 0x14) returns 1 and takes the semaphore when it is free, and returns 0 and leaves it held when it is already held.
- R8: A write to SEM_ADDR with bit 0 set frees the semaphore; a write with bit 0 clear has no effect.
- R9: Read data appears in the cycle after `rd_en` and holds until the next read; reads of unmapped addresses return 0 and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte address |
| wdata | input | DATA_W | Write data |
| avail | input | GROUPS*PER_GROUP | Per-copy availability, 1 = present |
| rdata | output | DATA_W | Registered read data |

## Verification
Every bus result is due one edge after its strobe: a write to the selector, semaphore or a copy is visible to a read issued in the next cycle, and read data is registered at the edge that captures `rd_en`. The bench raises a strobe just after a falling edge, drops it at the next falling edge and samples `rdata` there, half a cycle after the capturing edge. A reference model in the bench, updated in the same call that drives each write, gives the expected value of every read, so a copy's content is only ever observed through later reads of REG_ADDR after changes to the selector or the availability mask.

// File: rtl/steer_pkg.sv
package steer_pkg;
  // width of the group and instance fields of the selector
  localparam int FLD_W = 8;

  typedef struct packed {
    logic             mcast;
    logic [FLD_W-1:0] grp;
    logic [FLD_W-1:0] inst;
  } sel_t;

  localparam sel_t SEL_RESET = '{mcast: 1'b1, grp: '0, inst: '0};
endpackage

// File: rtl/steer_sel.sv
module steer_sel
  import steer_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int GROUPS    = 4,
  parameter int PER_GROUP = 4,
  localparam int N        = GROUPS * PER_GROUP,
  localparam int IDX_W    = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic [N-1:0]      avail,
  output sel_t              sel_q,
  output logic [IDX_W-1:0]  idx,
  output logic              idx_ok,
  output logic [DATA_W-1:0] sel_word
);
  localparam int WIDE_W = 2 * FLD_W + 1;

  logic [WIDE_W-1:0] wide_idx;
  logic              in_range;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= SEL_RESET;
    end else if (wr_sel) begin
      sel_q.mcast <= wdata[DATA_W-1];
      sel_q.grp   <= wdata[2*FLD_W-1:FLD_W];
      sel_q.inst  <= wdata[FLD_W-1:0];
    end
  end

  always_comb begin
    wide_idx = WIDE_W'(sel_q.grp) * WIDE_W'(PER_GROUP) + WIDE_W'(sel_q.inst);
    in_range = (int'(sel_q.grp) < GROUPS) && (int'(sel_q.inst) < PER_GROUP);
    idx      = IDX_W'(wide_idx);
    idx_ok   = in_range && avail[idx];
    sel_word = '0;
    sel_word[DATA_W-1]          = sel_q.mcast;
    sel_word[2*FLD_W-1:FLD_W]   = sel_q.grp;
    sel_word[FLD_W-1:0]         = sel_q.inst;
  end
endmodule

// File: rtl/steer_sem.sv
module steer_sem (
  input  logic clk,
  input  logic rst,
  input  logic take,
  input  logic give,
  output logic held
);
  always_ff @(posedge clk) begin
    if (rst)       held <= 1'b0;
    else if (give) held <= 1'b0;
    else if (take) held <= 1'b1;
  end
endmodule

// File: rtl/steer_store.sv
module steer_store #(
  parameter int DATA_W = 32,
  parameter int N      = 16,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_all,
  input  logic                wr_one,
  input  logic [IDX_W-1:0]    idx,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [N-1:0]        avail,
  output logic [N*DATA_W-1:0] bank
);
  for (genvar i = 0; i < N; i++) begin : g_copy
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else if ((wr_all && avail[i]) || (wr_one && idx == IDX_W'(i))) q <= wdata;
    end
    assign bank[i*DATA_W +: DATA_W] = q;
  end
endmodule

// File: rtl/steer_bank.sv
module steer_bank
  import steer_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 8,
  parameter int GROUPS    = 4,
  parameter int PER_GROUP = 4,
  parameter logic [ADDR_W-1:0] SEL_ADDR = 8'h10,
  parameter logic [ADDR_W-1:0] SEM_ADDR = 8'h14,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h20,
  localparam int N     = GROUPS * PER_GROUP,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [N-1:0]      avail,
  output logic [DATA_W-1:0] rdata
);
  sel_t                sel_q;
  logic [IDX_W-1:0]    idx;
  logic                idx_ok;
  logic [DATA_W-1:0]   sel_word;
  logic                sem_held;
  logic [N*DATA_W-1:0] bank;
  logic                hit_sel, hit_sem, hit_reg;
  logic [DATA_W-1:0]   rd_next;

  assign hit_sel = (addr == SEL_ADDR);
  assign hit_sem = (addr == SEM_ADDR);
  assign hit_reg = (addr == REG_ADDR);

  steer_sel #(.DATA_W(DATA_W), .GROUPS(GROUPS), .PER_GROUP(PER_GROUP)) u_sel (
    .clk(clk), .rst(rst), .wr_sel(wr_en && hit_sel), .wdata(wdata),
    .avail(avail), .sel_q(sel_q), .idx(idx), .idx_ok(idx_ok), .sel_word(sel_word)
  );

  steer_sem u_sem (
    .clk(clk), .rst(rst), .take(rd_en && hit_sem),
    .give(wr_en && hit_sem && wdata[0]), .held(sem_held)
  );

  steer_store #(.DATA_W(DATA_W), .N(N)) u_store (
    .clk(clk), .rst(rst),
    .wr_all(wr_en && hit_reg && sel_q.mcast),
    .wr_one(wr_en && hit_reg && !sel_q.mcast && idx_ok),
    .idx(idx), .wdata(wdata), .avail(avail), .bank(bank)
  );

  always_comb begin
    rd_next = '0;
    if (hit_sel)                rd_next = sel_word;
    else if (hit_sem)           rd_next[0] = !sem_held;
    else if (hit_reg && idx_ok) rd_next = bank[idx*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_next;
  end
endmodule

// File: rtl/steer_bank_chk.sv
module steer_bank_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int N      = 16,
  parameter logic [ADDR_W-1:0] SEM_ADDR = 8'h14,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h20
) (
  input logic                clk,
  input logic                rst,
  input logic                wr_en,
  input logic                rd_en,
  input logic [ADDR_W-1:0]   addr,
  input logic [DATA_W-1:0]   wdata,
  input logic [DATA_W-1:0]   rdata,
  input logic                held,
  input logic                idx_ok,
  input logic                mcast,
  input logic [N*DATA_W-1:0] bank
);
  // R6
  dead_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == REG_ADDR && !idx_ok) |=> (rdata == '0));

  // R6
  dead_unicast_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == REG_ADDR && !mcast && !idx_ok) |=> $stable(bank));

  // R7
  sem_busy_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == SEM_ADDR && held) |=> (rdata == '0 && held));

  // R7
  sem_take_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !wr_en && addr == SEM_ADDR && !held) |=> (rdata == DATA_W'(1) && held));

  // R8
  sem_give_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == SEM_ADDR && wdata[0]) |=> !held);

  // R9
  bank_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && addr == REG_ADDR) |=> $stable(bank));
endmodule

bind steer_bank steer_bank_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .N(GROUPS*PER_GROUP),
  .SEM_ADDR(SEM_ADDR), .REG_ADDR(REG_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .held(sem_held), .idx_ok(idx_ok),
  .mcast(sel_q.mcast), .bank(bank)
);

// File: tb/sim_steer_bank.sv
module sim_steer_bank;
  localparam int DW = 32, AW = 8, GR = 4, PG = 4, N = GR * PG;
  localparam logic [7:0] A_SEL = 8'h10, A_SEM = 8'h14, A_REG = 8'h20, A_BAD = 8'h30;

  logic          clk = 0, rst = 1, wr_en = 0, rd_en = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0, rdata;
  logic [N-1:0]  avail = '1;

  always #2 clk = ~clk;

  steer_bank u0 (.clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
                 .wdata(wdata), .avail(avail), .rdata(rdata));

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // reference model
  logic [DW-1:0] m_bank [N];
  logic          m_mc;
  int            m_grp, m_inst;
  logic          m_held;

  function automatic bit m_ok();
    if (m_grp >= GR || m_inst >= PG) return 0;
    return avail[m_grp*PG + m_inst];
  endfunction

  function automatic logic [DW-1:0] m_read(logic [7:0] a);
    if (a == A_SEL) return {m_mc, 15'd0, 8'(m_grp), 8'(m_inst)};
    if (a == A_SEM) return DW'(!m_held);
    if (a == A_REG) return m_ok() ? m_bank[m_grp*PG + m_inst] : '0;
    return '0;
  endfunction

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [7:0] a, logic [DW-1:0] d);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
    if (a == A_SEL) begin m_mc = d[31]; m_grp = d[15:8]; m_inst = d[7:0]; end
    else if (a == A_SEM) begin if (d[0]) m_held = 0; end
    else if (a == A_REG) begin
      if (m_mc) begin
        for (int i = 0; i < N; i++) if (avail[i]) m_bank[i] = d;
      end else if (m_ok()) m_bank[m_grp*PG + m_inst] = d;
    end
  endtask

  task automatic bus_rd(logic [7:0] a, string req);
    logic [DW-1:0] e;
    e = m_read(a);
    rd_en = 1; addr = a;
    @(negedge clk);
    rd_en = 0;
    check(req, rdata, e);
    if (a == A_SEM) m_held = 1;
  endtask

  task automatic steer(bit mc, int g, int i);
    bus_wr(A_SEL, {mc, 15'd0, 8'(g), 8'(i)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < N; i++) m_bank[i] = '0;
    m_mc = 1; m_grp = 0; m_inst = 0; m_held = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1 reset state
    bus_rd(A_SEL, "R1 selector reset");
    steer(0, 3, 3); bus_rd(A_REG, "R1 copy reset");
    bus_rd(A_SEM, "R1 sem free after reset");
    // R7 second read while held
    bus_rd(A_SEM, "R7 sem busy");
    // R8 write 0 no effect, write 1 frees
    bus_wr(A_SEM, 32'h0000_0002); bus_rd(A_SEM, "R8 write0 keeps held");
    bus_wr(A_SEM, 32'h1); bus_rd(A_SEM, "R8 release then take");
    bus_wr(A_SEM, 32'h1);

    // R2 field layout, unused bits read zero
    bus_wr(A_SEL, 32'h7fff_0201); bus_rd(A_SEL, "R2 selector fields");
    // R3 multicast skips absent copy 7
    avail = 16'hff7f;
    steer(1, 0, 0); bus_wr(A_REG, 32'hcafe_0001);
    steer(1, 2, 1); bus_rd(A_REG, "R3 multicast reaches copy 9");
    avail = '1;
    steer(0, 1, 3); bus_rd(A_REG, "R3 absent copy kept old value");
    // R4 unicast to index group*4+instance
    steer(0, 2, 3); bus_wr(A_REG, 32'h0bad_f00d);
    bus_rd(A_REG, "R4 unicast target");
    steer(0, 3, 2); bus_rd(A_REG, "R4 neighbour untouched");
    // R5 read with multicast set returns steered copy
    steer(1, 2, 3); bus_rd(A_REG, "R5 read under multicast");
    // R6 out-of-range and absent copies
    steer(0, 4, 0); bus_rd(A_REG, "R6 group out of range");
    steer(0, 0, 5); bus_wr(A_REG, 32'h1111_1111); bus_rd(A_REG, "R6 instance out of range");
    avail = 16'hfffe;
    steer(0, 0, 0); bus_wr(A_REG, 32'h2222_2222); bus_rd(A_REG, "R6 absent copy reads zero");
    avail = '1; bus_rd(A_REG, "R6 absent unicast dropped");
    // R9 unmapped address
    bus_wr(A_BAD, 32'hffff_ffff); bus_rd(A_BAD, "R9 unmapped reads zero");
    bus_rd(A_REG, "R9 unmapped write harmless");
    // R9 read data holds between reads
    repeat (3) @(negedge clk);
    check("R9 rdata held", rdata, m_read(A_REG));

    // constrained random mix
    for (int k = 0; k < 2000; k++) begin
      int op;
      op = $urandom_range(0, 9);
      if ($urandom_range(0, 15) == 0) avail = N'($urandom);
      case (op)
        0, 1: steer($urandom_range(0, 1), $urandom_range(0, 4), $urandom_range(0, 4));
        2, 3: bus_wr(A_REG, $urandom);
        4, 5, 6: bus_rd(A_REG, m_mc ? "R5 random read" : "R4 random read");
        7: bus_rd(A_SEM, "R7 random sem read");
        8: bus_wr(A_SEM, DW'($urandom_range(0, 1)));
        default: bus_rd(A_SEL, "R2 random selector read");
      endcase
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule